// File: doc/BRIEF.md
# Five-Port Rotating-Priority Output Arbiter

This block decides which of the five input ports of a 2D-mesh router may use one output channel. Each input port raises a request line when it holds a packet bound for this output. The arbiter answers with a registered one-hot grant to exactly one requester. It also gives the encoded index of that port, which drives the crossbar select lines. The grant stays in place until the transfer it covers ends, which a one-cycle done pulse marks. After that, priority moves around a fixed ring, so that the port just served drops to the lowest priority.

The ring runs North, East, South, West, Local, and then wraps back to North. When an instance drives the East or West output, it never sees North or South traffic, because dimension-ordered routing moves a packet horizontally before it moves vertically. A parameter marks such instances. In those instances the North and South request lines are cut off at the input, and no logic is built for them.

Top module: `rr_out_arb`

## Requirements
- R1: Port indices are North=0, East=1, South=2, West=3 and Local=4, and req, grant and the encoded index use these bit positions and values. Arbitration scans the ring in the order 0,1,2,3,4,0 and starts at the port just after the last-served port. The first eligible requester found wins.
- R2: After reset the last-served port is Local (4), so North has the highest priority in the first arbitration.
- R3: A grant goes only to a port whose request is asserted, and at most one grant bit is high at any time.
- R4: The grant is registered. It appears on the clock edge that samples a valid request while the arbiter is idle.
- R5: While a grant is held, it stays unchanged whatever the request lines do, until done is sampled high.
- R6: When done is sampled high while a grant is held, the last-served port becomes the granted port and the grant clears on that same edge. A new arbitration can happen on the following edge. A done pulse while idle has no effect.
- R7: When no eligible request is present, the grant is all zeros, grant_valid is low, grant_idx is 0, and the last-served port does not change.
- R8: When the parameter OUT_PORT is 1 (East) or 3 (West), the North and South requests are never granted and do not affect the rotation.
- R9: grant_valid is high exactly when a grant bit is high, and grant_idx gives the index of that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 5 | Request per input port, bit index = port index |
| done | input | 1 | One-cycle pulse that ends the granted transfer |
| grant | output | 5 | Registered one-hot grant |
| grant_valid | output | 1 | High while any grant bit is high |
| grant_idx | output | 3 | Encoded index of the granted port |

## Verification
The bench goes after the wrap of the ring from Local back to North. A design with a wrong modulo would grant Local twice or skip North. It runs cases where the winner sits several positions from the pointer, which catch a scan that stops too early or searches in the wrong direction. It drops and changes requests while a grant is held, to catch a grant that follows the request lines and so corrupts the crossbar in mid-packet. It sends done pulses with no grant outstanding, which catches a pointer that moves when nothing was served. In an East-output instance it offers only North and South requests; a design that did not prune them would grant a port whose packets can never arrive there.

// File: rtl/rr_arb_pkg.sv
package rr_arb_pkg;
  localparam int NPORTS = 5;
  localparam int IDX_W  = $clog2(NPORTS);

  localparam logic [IDX_W-1:0] P_NORTH = 3'd0;
  localparam logic [IDX_W-1:0] P_EAST  = 3'd1;
  localparam logic [IDX_W-1:0] P_SOUTH = 3'd2;
  localparam logic [IDX_W-1:0] P_WEST  = 3'd3;
  localparam logic [IDX_W-1:0] P_LOCAL = 3'd4;

  typedef enum logic {ST_IDLE, ST_HOLD} arb_state_e;

  // Index k steps after idx around the ring of NPORTS ports.
  function automatic logic [IDX_W-1:0] ring_step(input logic [IDX_W-1:0] idx, input int k);
    int s;
    s = int'(idx) + k;
    if (s >= NPORTS) s = s - NPORTS;
    return IDX_W'(s);
  endfunction

  function automatic logic [NPORTS-1:0] idx_to_onehot(input logic [IDX_W-1:0] idx);
    return NPORTS'(1) << idx;
  endfunction
endpackage

// File: rtl/rr_req_mask.sv
module rr_req_mask
  import rr_arb_pkg::*;
#(
  parameter int OUT_PORT = 4
) (
  input  logic [NPORTS-1:0] req,
  output logic [NPORTS-1:0] elig
);
  localparam bit HORIZ = (OUT_PORT == int'(P_EAST)) || (OUT_PORT == int'(P_WEST));

  for (genvar p = 0; p < NPORTS; p++) begin : g_bit
    if (HORIZ && (p == int'(P_NORTH) || p == int'(P_SOUTH))) begin : g_cut
      assign elig[p] = 1'b0;
    end else begin : g_keep
      assign elig[p] = req[p];
    end
  end
endmodule

// File: rtl/rr_ring_pick.sv
module rr_ring_pick
  import rr_arb_pkg::*;
(
  input  logic [IDX_W-1:0]  last,
  input  logic [NPORTS-1:0] elig,
  output logic              found,
  output logic [IDX_W-1:0]  pick
);
  logic [IDX_W-1:0] cand [NPORTS];
  logic [NPORTS-1:0] hit;

  // Offset k+1 from the last-served port; offset 1 has the highest priority.
  for (genvar k = 0; k < NPORTS; k++) begin : g_off
    assign cand[k] = ring_step(last, k + 1);
    assign hit[k]  = elig[cand[k]];
  end

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 0; k < NPORTS; k++) begin
      if (hit[k] && !found) begin
        found = 1'b1;
        pick  = cand[k];
      end
    end
  end
endmodule

// File: rtl/rr_out_arb.sv
module rr_out_arb
  import rr_arb_pkg::*;
#(
  parameter int OUT_PORT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  req,
  input  logic        done,
  output logic [4:0]  grant,
  output logic        grant_valid,
  output logic [2:0]  grant_idx
);
  arb_state_e        state_q;
  logic [IDX_W-1:0]  last_q;
  logic [IDX_W-1:0]  idx_q;
  logic [NPORTS-1:0] grant_q;
  logic [NPORTS-1:0] elig;
  logic              pick_found;
  logic [IDX_W-1:0]  pick_idx;

  // Named internal events
  logic              ev_issue;
  logic              ev_release;

  rr_req_mask #(.OUT_PORT(OUT_PORT)) u_mask (
    .req  (req),
    .elig (elig)
  );

  rr_ring_pick u_pick (
    .last  (last_q),
    .elig  (elig),
    .found (pick_found),
    .pick  (pick_idx)
  );

  assign ev_issue   = (state_q == ST_IDLE) && pick_found;
  assign ev_release = (state_q == ST_HOLD) && done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      last_q  <= P_LOCAL;
      idx_q   <= '0;
      grant_q <= '0;
    end else if (ev_issue) begin
      state_q <= ST_HOLD;
      idx_q   <= pick_idx;
      grant_q <= idx_to_onehot(pick_idx);
    end else if (ev_release) begin
      state_q <= ST_IDLE;
      last_q  <= idx_q;
      idx_q   <= '0;
      grant_q <= '0;
    end
  end

  assign grant       = grant_q;
  assign grant_valid = (state_q == ST_HOLD);
  assign grant_idx   = idx_q;

  // R3: never more than one grant bit
  assert_onehot_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R3: a new grant only lands on a port that was eligible when sampled
  assert_grant_requested_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_valid) |-> ((grant & $past(elig)) == grant));

  // R5: grant frozen while held and no done
  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !done) |=> ($stable(grant) && $stable(grant_idx)));

  // R6: done clears the grant on the next edge
  assert_done_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && done) |=> !grant_valid);

  // R6: pointer only moves on a release, and to the released port
  assert_pointer_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(last_q) |-> ($past(ev_release) && last_q == $past(grant_idx)));

  // R7: idle with nothing eligible stays idle
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_valid && elig == '0) |=> !grant_valid);

  // R9: valid flag agrees with the grant vector
  assert_valid_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid == (grant != '0));

  if ((OUT_PORT == int'(P_EAST)) || (OUT_PORT == int'(P_WEST))) begin : g_horiz_chk
    // R8: vertical inputs never served on a horizontal output
    assert_no_vertical_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !grant[P_NORTH] && !grant[P_SOUTH]);
  end
endmodule

// File: tb/test_rr_out_arb.sv
module test_rr_out_arb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] req = '0, req_h = '0;
  logic done = 1'b0, done_h = 1'b0;
  logic [4:0] grant, grant_h;
  logic grant_valid, grant_valid_h;
  logic [2:0] grant_idx, grant_idx_h;

  int n_checks = 0;
  int n_fail = 0;

  always #2 clk = ~clk;   // 250 MHz

  rr_out_arb i_rr_out_arb (
    .clk(clk), .rst_n(rst_n), .req(req), .done(done),
    .grant(grant), .grant_valid(grant_valid), .grant_idx(grant_idx)
  );

  rr_out_arb #(.OUT_PORT(1)) i_rr_out_arb_east (
    .clk(clk), .rst_n(rst_n), .req(req_h), .done(done_h),
    .grant(grant_h), .grant_valid(grant_valid_h), .grant_idx(grant_idx_h)
  );

  // {req[4:0], expected winner index[2:0]}, applied in order from reset.
  localparam logic [7:0] VEC [10] = '{
    8'b11111_000,  // after reset: North first (R2)
    8'b11111_001,  // last North -> East
    8'b00001_000,  // only North
    8'b10100_010,  // last North: South before Local
    8'b10101_100,  // last South: West idle, Local wins
    8'b01010_001,  // last Local: wrap, North idle, East
    8'b01010_011,  // last East: South idle, West
    8'b00010_001,  // last West: only East
    8'b00011_000,  // last East: wrap past Local to North
    8'b10000_100   // only Local
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] oh(input logic [2:0] i);
    logic [4:0] v = '0;
    v[i] = 1'b1;
    return v;
  endfunction

  task automatic chk_grant(input string tag, input logic [2:0] exp);
    chk({tag, " grant"}, 32'(grant), 32'(oh(exp)));
    chk({tag, " valid"}, 32'(grant_valid), 32'd1);
    chk({tag, " idx"}, 32'(grant_idx), 32'(exp));
  endtask

  task automatic chk_idle(input string tag);
    chk({tag, " grant"}, 32'(grant), 32'd0);
    chk({tag, " valid"}, 32'(grant_valid), 32'd0);
    chk({tag, " idx"}, 32'(grant_idx), 32'd0);
  endtask

  // Drive req at a falling edge, check after one rising edge, then pulse done.
  task automatic round(input string tag, input logic [4:0] r, input logic [2:0] exp);
    @(negedge clk); req = r;
    @(negedge clk); chk_grant(tag, exp);
    req = '0; done = 1'b1;
    @(negedge clk); done = 1'b0;
    chk_idle({tag, " release R6"});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("R2 reset");
    rst_n = 1'b1;

    for (int i = 0; i < 10; i++) begin
      round($sformatf("R1 vec%0d", i), VEC[i][7:3], VEC[i][2:0]);
    end
    // pointer now Local

    // R7: no requests for several cycles, nothing granted, pointer kept
    @(negedge clk); req = '0;
    repeat (3) @(negedge clk);
    chk_idle("R7 no request");
    // R6: done while idle is ignored
    done = 1'b1; @(negedge clk); done = 1'b0;
    chk_idle("R6 idle done");
    round("R7 pointer kept", 5'b11111, 3'd0);

    // R4/R5: grant timing and hold under changing requests
    @(negedge clk); req = 5'b00100;   // South, last North
    chk_idle("R4 before edge");
    @(negedge clk); chk_grant("R4 one edge", 3'd2);
    req = 5'b00010;
    @(negedge clk); chk_grant("R5 hold req change", 3'd2);
    req = '0;
    repeat (2) @(negedge clk);
    chk_grant("R5 hold req drop", 3'd2);
    req = 5'b00010; done = 1'b1;
    @(negedge clk); done = 1'b0;
    chk_idle("R6 clear on done");
    @(negedge clk); chk_grant("R6 next arbitration", 3'd1);
    req = '0; done = 1'b1;
    @(negedge clk); done = 1'b0;

    // R8: East-output instance
    @(negedge clk); req_h = 5'b00101;
    repeat (2) @(negedge clk);
    chk("R8 vertical only grant", 32'(grant_h), 32'd0);
    chk("R8 vertical only valid", 32'(grant_valid_h), 32'd0);
    req_h = 5'b11111;
    @(negedge clk);
    chk("R8 all skip North grant", 32'(grant_h), 32'(oh(3'd1)));
    chk("R8 all skip North idx R9", 32'(grant_idx_h), 32'd1);
    done_h = 1'b1; @(negedge clk); done_h = 1'b0;
    @(negedge clk);
    chk("R8 skip South grant", 32'(grant_h), 32'(oh(3'd3)));
    chk("R8 skip South valid R9", 32'(grant_valid_h), 32'd1);
    req_h = '0; done_h = 1'b1; @(negedge clk); done_h = 1'b0;
    chk("R8 released", 32'(grant_valid_h), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule